// File: doc/BRIEF.md
# Follower Sample Integration Controller

This block runs the follower side of one detector channel. A leader controller steers it with short typed messages. One message arms the follower. A second opens an integration window whose length is a count of ADC sample strobes. A third asks for the integrated result, and a fourth disarms the channel. Each accepted message is answered with a response of the same type code, so the leader always knows which phase the follower has entered.

While a window is open, every strobed ADC word is added into an accumulator. The accumulator is wide enough that the largest window of full-scale samples cannot wrap. Once the window has counted its samples, the sum is frozen until the leader fetches it. The follower then waits for the next window request. A request that makes no sense in the current phase is consumed and dropped, and the block raises a one-cycle error pulse.

Both message paths are valid/ready streams. The response path holds its word until the leader takes it. The request path is back-pressured only while a response is stuck: `req_ready` is high whenever the response slot is empty or is being drained in that same cycle. The ADC path has no back-pressure: a strobe that arrives outside an open window is discarded.

Top module: `follower_integ_ctrl`

## Requirements
- R1: After reset, `rsp_valid` and `err_pulse` are low, `req_ready` is high, and the controller is idle, where only an arm request is legal.
- R2: An arm request (type code 0) while idle produces a response of type 0 with `rsp_ack` high, and the controller moves to the waiting phase. All other responses carry `rsp_ack` low.
- R3: A window request (type code 1) while waiting produces a type 1 response, clears the sum and loads the window length from `req_len`. A length of zero completes the window at once with a sum of zero. A length above `MAX_WIN` is clamped to `MAX_WIN`.
- R4: While a window is open, each cycle with `adc_valid` high adds `adc_data` to the sum. Samples are counted from the cycle after the window request is accepted. After the last counted sample the sum is frozen. Samples in any other phase are ignored.
- R5: A fetch request (type code 2) after the window has completed produces a type 2 response whose `rsp_data` equals the sum, and the controller returns to waiting.
- R6: A disarm request (type code 3) while waiting, integrating or complete produces a type 3 response and returns the controller to idle. A disarm accepted in the same cycle as the final sample of a window takes priority over the window completing.
- R7: A request that is illegal in the current phase is accepted, gets no response and leaves the phase unchanged. The one exception is an illegal request that lands on the final sample, where the window still completes. Each illegal request raises `err_pulse` for exactly one cycle.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response word stays unchanged and `req_ready` is low. Otherwise `req_ready` is high.
- R9: A window of `MAX_WIN` full-scale samples yields the exact sum, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request word offered |
| req_ready | output | 1 | Request word accepted when high with req_valid |
| req_type | input | 2 | Request type code (0 arm, 1 window, 2 fetch, 3 disarm) |
| req_len | input | WIN_W | Window length in samples, used by window requests |
| adc_valid | input | 1 | ADC sample strobe |
| adc_data | input | ADC_W | ADC sample, unsigned |
| rsp_valid | output | 1 | Response word offered |
| rsp_ready | input | 1 | Leader takes the response |
| rsp_type | output | 2 | Response type code, equal to the request answered |
| rsp_ack | output | 1 | High on arm responses |
| rsp_data | output | ACC_W | Integrated sum on fetch responses, zero otherwise |
| err_pulse | output | 1 | One-cycle pulse per illegal request |

## Verification
The final sample of a window and an incoming request can land in the same cycle. The outcome then depends on which transition wins. The bench drives the last ADC strobe together with a disarm request and expects a disarm response and an idle controller, which it confirms with a fetch that is refused. It then drives the last strobe together with a premature fetch and expects an error pulse with no response, and then a completed window whose full sum a second fetch returns.

// File: rtl/fic_pkg.sv
package fic_pkg;

  typedef enum logic [1:0] {
    MSG_ARM   = 2'd0,
    MSG_WIN   = 2'd1,
    MSG_FETCH = 2'd2,
    MSG_DISARM = 2'd3
  } msg_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_INTG = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

endpackage

// File: rtl/fic_win_ctr.sv
module fic_win_ctr #(
  parameter int MAX_WIN = 1024,
  parameter int WIN_W   = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIN_W-1:0] len,
  input  logic             smp,
  output logic [WIN_W-1:0] remain,
  output logic             last
);

  localparam logic [WIN_W-1:0] MAX_L = WIN_W'(MAX_WIN);

  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] len_clamped;

  assign len_clamped = (len > MAX_L) ? MAX_L : len;
  assign last        = smp && (cnt_q == WIN_W'(1));
  assign remain      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len_clamped;
    end else if (smp && cnt_q != '0) begin
      cnt_q <= cnt_q - WIN_W'(1);
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_L); // R3

endmodule

// File: rtl/fic_accum.sv
module fic_accum #(
  parameter int ADC_W = 12,
  parameter int ACC_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [ADC_W-1:0] din,
  output logic [ACC_W-1:0] sum
);

  logic [ACC_W-1:0] sum_q;
  logic [ACC_W-1:0] din_ext;

  assign din_ext = {{(ACC_W-ADC_W){1'b0}}, din};
  assign sum     = sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (clr) begin
      sum_q <= '0;
    end else if (add) begin
      sum_q <= sum_q + din_ext;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr) |=> (sum_q >= $past(sum_q))); // R9

endmodule

// File: rtl/fic_rsp_slot.sv
module fic_rsp_slot #(
  parameter int ACC_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       ld_type,
  input  logic             ld_ack,
  input  logic [ACC_W-1:0] ld_data,
  input  logic             ready,
  output logic             valid,
  output logic [1:0]       rtype,
  output logic             ack,
  output logic [ACC_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      rtype <= '0;
      ack   <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      rtype <= ld_type;
      ack   <= ld_ack;
      data  <= ld_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(rtype) && $stable(ack) && $stable(data))); // R8

  AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid || ready)); // R8

endmodule

// File: rtl/follower_integ_ctrl.sv
module follower_integ_ctrl
  import fic_pkg::*;
#(
  parameter int ADC_W   = 12,
  parameter int MAX_WIN = 1024,
  localparam int WIN_W  = $clog2(MAX_WIN + 1),
  localparam int ACC_W  = ADC_W + WIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_type,
  input  logic [WIN_W-1:0] req_len,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_type,
  output logic             rsp_ack,
  output logic [ACC_W-1:0] rsp_data,
  output logic             err_pulse
);

  phase_e           phase_q, phase_d;
  msg_e             msg;
  logic             req_fire;
  logic             legal;
  logic             win_start;
  logic             smp_en;
  logic             win_last;
  logic [WIN_W-1:0] win_remain;
  logic [ACC_W-1:0] acc_sum;
  logic             ld_ack;
  logic [ACC_W-1:0] ld_data;
  logic             err_q;

  assign msg       = msg_e'(req_type);
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign smp_en    = adc_valid && (phase_q == PH_INTG);
  assign err_pulse = err_q;

  // phase sequencing and request legality
  always_comb begin
    phase_d   = phase_q;
    legal     = 1'b0;
    win_start = 1'b0;
    ld_ack    = 1'b0;
    ld_data   = '0;
    case (phase_q)
      PH_IDLE: begin
        if (req_fire && msg == MSG_ARM) begin
          legal   = 1'b1;
          ld_ack  = 1'b1;
          phase_d = PH_WAIT;
        end
      end
      PH_WAIT: begin
        if (req_fire && msg == MSG_WIN) begin
          legal     = 1'b1;
          win_start = 1'b1;
          phase_d   = (req_len == '0) ? PH_DONE : PH_INTG;
        end else if (req_fire && msg == MSG_DISARM) begin
          legal   = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      PH_INTG: begin
        if (req_fire && msg == MSG_DISARM) begin
          legal   = 1'b1;
          phase_d = PH_IDLE;
        end else if (win_last) begin
          phase_d = PH_DONE;
        end
      end
      PH_DONE: begin
        if (req_fire && msg == MSG_FETCH) begin
          legal   = 1'b1;
          ld_data = acc_sum;
          phase_d = PH_WAIT;
        end else if (req_fire && msg == MSG_DISARM) begin
          legal   = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_q   <= req_fire && !legal;
    end
  end

  fic_win_ctr #(
    .MAX_WIN (MAX_WIN),
    .WIN_W   (WIN_W)
  ) i_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (win_start),
    .len    (req_len),
    .smp    (smp_en),
    .remain (win_remain),
    .last   (win_last)
  );

  fic_accum #(
    .ADC_W (ADC_W),
    .ACC_W (ACC_W)
  ) i_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (win_start),
    .add   (smp_en),
    .din   (adc_data),
    .sum   (acc_sum)
  );

  fic_rsp_slot #(
    .ACC_W (ACC_W)
  ) i_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (legal),
    .ld_type (req_type),
    .ld_ack  (ld_ack),
    .ld_data (ld_data),
    .ready   (rsp_ready),
    .valid   (rsp_valid),
    .rtype   (rsp_type),
    .ack     (rsp_ack),
    .data    (rsp_data)
  );

  AST_IDLE_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |=> $stable(acc_sum)); // R4

  AST_INTG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INTG) |-> (win_remain != '0)); // R3

  AST_ERR_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ((phase_q == $past(phase_q)) || ($past(phase_q) == PH_INTG))); // R7

  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && !req_fire) |=> (phase_q == PH_DONE)); // R5

endmodule

// File: tb/test_follower_integ_ctrl.sv
module test_follower_integ_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADC_W   = 12;
  localparam int MAX_WIN = 1024;
  localparam int WIN_W   = 11;
  localparam int ACC_W   = 23;

  // {type[14:13], len[12:2], expect_rsp[1], expect_err[0]}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {2'd2, 11'd0, 1'b0, 1'b1},  // idle: fetch illegal (R7)
    {2'd0, 11'd0, 1'b1, 1'b0},  // idle: arm (R2)
    {2'd0, 11'd0, 1'b0, 1'b1},  // wait: arm illegal (R7)
    {2'd2, 11'd0, 1'b0, 1'b1},  // wait: fetch illegal (R7)
    {2'd1, 11'd0, 1'b1, 1'b0},  // wait: zero window (R3)
    {2'd1, 11'd0, 1'b0, 1'b1},  // done: window illegal (R7)
    {2'd2, 11'd0, 1'b1, 1'b0},  // done: fetch, sum 0 (R5)
    {2'd3, 11'd0, 1'b1, 1'b0},  // wait: disarm (R6)
    {2'd3, 11'd0, 1'b0, 1'b1},  // idle: disarm illegal (R7)
    {2'd0, 11'd0, 1'b1, 1'b0},  // idle: arm (R2)
    {2'd1, 11'd5, 1'b1, 1'b0},  // wait: window 5 (R3)
    {2'd2, 11'd0, 1'b0, 1'b1},  // integrating: fetch illegal (R7)
    {2'd3, 11'd0, 1'b1, 1'b0},  // integrating: disarm (R6)
    {2'd1, 11'd0, 1'b0, 1'b1}   // idle: window illegal (R7)
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_type = '0;
  logic [WIN_W-1:0] req_len = '0;
  logic             adc_valid = 1'b0;
  logic [ADC_W-1:0] adc_data = '0;
  logic             rsp_valid;
  logic             rsp_ready = 1'b1;
  logic [1:0]       rsp_type;
  logic             rsp_ack;
  logic [ACC_W-1:0] rsp_data;
  logic             err_pulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  follower_integ_ctrl #(.ADC_W(ADC_W), .MAX_WIN(MAX_WIN)) i_follower_integ_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_len(req_len), .adc_valid(adc_valid), .adc_data(adc_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type), .rsp_ack(rsp_ack),
    .rsp_data(rsp_data), .err_pulse(err_pulse)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input logic [WIN_W-1:0] l);
    req_valid = 1'b1;
    req_type  = t;
    req_len   = l;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic samples(input int n, input int v);
    for (int i = 0; i < n; i++) begin
      adc_valid = 1'b1;
      adc_data  = ADC_W'(v);
      @(negedge clk);
    end
    adc_valid = 1'b0;
  endtask

  task automatic fetch_expect(input string req, input int exp);
    send(2'd2, '0);
    chk({req, " fetch valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " fetch type"}, 64'(rsp_type), 64'd2);
    chk({req, " fetch sum"}, 64'(rsp_data), 64'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 err_pulse", 64'(err_pulse), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k][14:13], VEC[k][12:2]);
      chk($sformatf("R7 vec%0d err", k), 64'(err_pulse), 64'(VEC[k][0]));
      chk($sformatf("R8 vec%0d rsp", k), 64'(rsp_valid), 64'(VEC[k][1]));
      if (VEC[k][1]) begin
        chk($sformatf("R2 vec%0d type", k), 64'(rsp_type), 64'(VEC[k][14:13]));
        chk($sformatf("R2 vec%0d ack", k), 64'(rsp_ack), 64'(VEC[k][14:13] == 2'd0));
        if (VEC[k][14:13] == 2'd2) chk("R5 zero window sum", 64'(rsp_data), 64'd0);
      end
      @(negedge clk);
      chk($sformatf("R7 vec%0d err one cycle", k), 64'(err_pulse), 64'd0);
    end

    // R4: samples while waiting ignored, gaps honoured, excess after window ignored
    send(2'd0, '0);
    samples(3, 100);
    send(2'd1, 11'd4);
    samples(1, 10);
    @(negedge clk);
    samples(2, 20);
    samples(1, 4095);
    samples(1, 777);
    fetch_expect("R4 gapped window", 10 + 20 + 20 + 4095);

    // R3: sum cleared on new window
    send(2'd1, 11'd2);
    samples(1, 5);
    samples(1, 6);
    fetch_expect("R3 cleared sum", 11);

    // R9: full-scale maximum window
    send(2'd1, 11'(MAX_WIN));
    samples(MAX_WIN, 4095);
    fetch_expect("R9 full scale", 4095 * MAX_WIN);

    // R3: oversize length clamped
    send(2'd1, 11'd2000);
    samples(MAX_WIN + 76, 1);
    fetch_expect("R3 clamp", MAX_WIN);

    // R7/R4: premature fetch on the final sample
    send(2'd1, 11'd3);
    samples(1, 7);
    samples(1, 8);
    adc_valid = 1'b1; adc_data = 12'd9;
    send(2'd2, '0);
    adc_valid = 1'b0;
    chk("R7 collide fetch err", 64'(err_pulse), 64'd1);
    chk("R7 collide fetch no rsp", 64'(rsp_valid), 64'd0);
    fetch_expect("R4 collide window done", 24);

    // R6: disarm on the final sample wins
    send(2'd1, 11'd3);
    samples(2, 1);
    adc_valid = 1'b1; adc_data = 12'd1;
    send(2'd3, '0);
    adc_valid = 1'b0;
    chk("R6 collide disarm rsp", 64'(rsp_valid), 64'd1);
    chk("R6 collide disarm type", 64'(rsp_type), 64'd3);
    send(2'd2, '0);
    chk("R6 idle after disarm", 64'(err_pulse), 64'd1);
    send(2'd0, '0);
    chk("R6 rearm", 64'(rsp_ack), 64'd1);

    // R8: back-pressure on response
    @(negedge clk);
    rsp_ready = 1'b0;
    send(2'd1, '0);
    req_valid = 1'b1; req_type = 2'd2; req_len = '0;
    for (int c = 0; c < 3; c++) begin
      chk("R8 held valid", 64'(rsp_valid), 64'd1);
      chk("R8 held type", 64'(rsp_type), 64'd1);
      chk("R8 ready low", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 drained then fetch type", 64'(rsp_type), 64'd2);
    chk("R8 fetch valid", 64'(rsp_valid), 64'd1);
    chk("R8 fetch sum", 64'(rsp_data), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule